// File: doc/BRIEF.md
# Bucket Address Delay Splitter

This block converts a requested storage-ring bucket address into the two delay settings needed to aim an injected beam at that bucket. The event clock runs at one quarter of the RF frequency, so one event-clock tick (about 8 ns) covers four RF buckets. The address is therefore split into a coarse part, the address divided by four, expressed in event-clock ticks, and a fine part, the address modulo four, expressed as a gun phase shift in 2 ns steps.

The block is fed one sequence-table entry at a time: a base timestamp, a flag telling whether the entry belongs to the injection beam path, the bucket address and a valid strobe. For flagged entries the coarse offset is added to the base timestamp, saturating at the top of the timestamp range. Unflagged entries pass their base timestamp through unchanged. The fine gun code is produced for every accepted entry. Addresses past the last bucket are refused and reported with an error pulse, and the previous results are kept.

Top module: `bucket_delay_splitter`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid`, `addr_err`, `adj_ts` and `fine_code` are all zero.
- R2: An accepted entry (`in_valid` high, `bucket_addr` at most 827) produces `out_valid` high exactly one clock later, for one cycle per accepted input cycle.
- R3: For an accepted entry with `inj_entry` high, `adj_ts` equals `base_ts` plus `bucket_addr` divided by 4 (integer division), e.g. address 132, 133 and 134 each add 33 ticks.
- R4: For every accepted entry `fine_code` equals `bucket_addr` modulo 4, a 2-bit code whose gun delay is the code times 2 ns, independent of `inj_entry`.
- R5: For an accepted entry with `inj_entry` low, `adj_ts` equals `base_ts` unchanged.
- R6: An entry with `bucket_addr` greater than 827 is refused: one clock later `addr_err` is high, `out_valid` is low, and `adj_ts` and `fine_code` keep their previous values.
- R7: When the sum of `base_ts` and the coarse offset exceeds 2^32-1, `adj_ts` becomes 2^32-1 instead of wrapping; a sum exactly equal to 2^32-1 is passed as is.
- R8: The edge addresses are handled: address 0 gives offset 0 and code 0, address 827 gives offset 206 and code 3.
- R9: A cycle with `in_valid` low leaves `out_valid` and `addr_err` low one clock later and `adj_ts` and `fine_code` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Entry present on the inputs this cycle |
| bucket_addr | input | 10 | Requested storage-ring bucket, 0 to 827 legal |
| base_ts | input | 32 | Base timestamp of the entry in event-clock ticks |
| inj_entry | input | 1 | High when the entry belongs to the injection beam path |
| out_valid | output | 1 | Result registers updated with an accepted entry |
| adj_ts | output | 32 | Adjusted timestamp in event-clock ticks |
| fine_code | output | 2 | Gun phase shift code, delay = code x 2 ns |
| addr_err | output | 1 | One-cycle pulse after a refused address |

## Verification
The bench aims at the address split at the four residues around one tick boundary, where a design that shifted by the wrong amount or took the wrong low bits would report 33 ticks with the wrong phase or step the tick one bucket early. It drives addresses 0, 827, 828 and 1023, catching an off-by-one range check that would either refuse the last bucket or accept a nonexistent one and overwrite the held results. Timestamps near the top of the range, one landing exactly on the maximum and one past it, expose a design that wraps around to a small value or saturates one step too soon. Unflagged entries with large addresses show whether the offset leaks into entries that must keep their base timestamp.

// File: rtl/bds_pkg.sv
package bds_pkg;

  // Classification of the entry seen at the inputs in one cycle.
  typedef enum logic [1:0] {
    ENTRY_IDLE = 2'd0,
    ENTRY_OK   = 2'd1,
    ENTRY_BAD  = 2'd2
  } entry_status_e;

endpackage

// File: rtl/bds_addr_split.sv
module bds_addr_split #(
  parameter int ADDR_W       = 10,
  parameter int BUCKET_COUNT = 828,
  parameter int STEP_BUCKETS = 4,
  localparam int FINE_W      = (STEP_BUCKETS > 1) ? $clog2(STEP_BUCKETS) : 1,
  localparam int SHIFT       = (STEP_BUCKETS > 1) ? $clog2(STEP_BUCKETS) : 0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] coarse,
  output logic [FINE_W-1:0] fine,
  output logic              in_range
);

  localparam int LAST_BUCKET = BUCKET_COUNT - 1;

  assign in_range = (addr <= ADDR_W'(LAST_BUCKET));
  assign coarse   = addr >> SHIFT;

  // Buckets per tick is a power of two; the residual phase is the low bits.
  generate
    if (STEP_BUCKETS > 1) begin : g_residual
      assign fine = addr[FINE_W-1:0];
    end else begin : g_no_residual
      assign fine = '0;
    end
  endgenerate

  // R3 / R4: coarse and fine recombine into the requested address.
  always_comb begin
    if (in_range) begin
      a_r4_split_recombines : assert (((coarse << SHIFT) | ADDR_W'(fine)) == addr)
        else $error("address split does not recombine");
    end
  end

endmodule

// File: rtl/bds_ts_adjust.sv
module bds_ts_adjust #(
  parameter int TS_W   = 32,
  parameter int ADDR_W = 10
) (
  input  logic [TS_W-1:0]   base_ts,
  input  logic [ADDR_W-1:0] coarse,
  input  logic              shift_en,
  output logic [TS_W-1:0]   ts_out
);

  localparam logic [TS_W-1:0] TS_MAX = '1;

  logic [TS_W:0] wide_sum;

  assign wide_sum = {1'b0, base_ts} + (TS_W+1)'(coarse);

  always_comb begin
    if (!shift_en)
      ts_out = base_ts;
    else if (wide_sum[TS_W])
      ts_out = TS_MAX;
    else
      ts_out = wide_sum[TS_W-1:0];
  end

  // R7: a shifted timestamp never lands below its base (no wrap).
  always_comb begin
    if (shift_en) begin
      a_r7_no_wrap : assert (ts_out >= base_ts)
        else $error("adjusted timestamp wrapped");
    end
  end

endmodule

// File: rtl/bucket_delay_splitter.sv
module bucket_delay_splitter #(
  parameter int ADDR_W       = 10,
  parameter int TS_W         = 32,
  parameter int BUCKET_COUNT = 828,
  parameter int STEP_BUCKETS = 4,
  localparam int FINE_W      = (STEP_BUCKETS > 1) ? $clog2(STEP_BUCKETS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] bucket_addr,
  input  logic [TS_W-1:0]   base_ts,
  input  logic              inj_entry,
  output logic              out_valid,
  output logic [TS_W-1:0]   adj_ts,
  output logic [FINE_W-1:0] fine_code,
  output logic              addr_err
);

  import bds_pkg::*;

  localparam int LAST_BUCKET = BUCKET_COUNT - 1;

  logic [ADDR_W-1:0] coarse;
  logic [FINE_W-1:0] fine;
  logic              in_range;
  logic [TS_W-1:0]   ts_next;
  entry_status_e     status;

  bds_addr_split #(
    .ADDR_W       (ADDR_W),
    .BUCKET_COUNT (BUCKET_COUNT),
    .STEP_BUCKETS (STEP_BUCKETS)
  ) u_split (
    .addr     (bucket_addr),
    .coarse   (coarse),
    .fine     (fine),
    .in_range (in_range)
  );

  bds_ts_adjust #(
    .TS_W   (TS_W),
    .ADDR_W (ADDR_W)
  ) u_adjust (
    .base_ts  (base_ts),
    .coarse   (coarse),
    .shift_en (inj_entry),
    .ts_out   (ts_next)
  );

  always_comb begin
    if (!in_valid)
      status = ENTRY_IDLE;
    else if (in_range)
      status = ENTRY_OK;
    else
      status = ENTRY_BAD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      addr_err  <= 1'b0;
      adj_ts    <= '0;
      fine_code <= '0;
    end else begin
      out_valid <= (status == ENTRY_OK);
      addr_err  <= (status == ENTRY_BAD);
      if (status == ENTRY_OK) begin
        adj_ts    <= ts_next;
        fine_code <= fine;
      end
    end
  end

  // R2: a result appears only one cycle after a strobe.
  a_r2_valid_follows_strobe : assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid))
    else $error("out_valid without a preceding strobe");

  // R6: a refused address raises the error and freezes the results.
  a_r6_bad_addr_held : assert property (@(posedge clk) disable iff (rst)
    (in_valid && bucket_addr > ADDR_W'(LAST_BUCKET)) |=>
      (addr_err && !out_valid && $stable(adj_ts) && $stable(fine_code)))
    else $error("refused address changed the outputs");

  // R6: error and valid never coincide.
  a_r6_err_excludes_valid : assert property (@(posedge clk) disable iff (rst)
    !(addr_err && out_valid))
    else $error("addr_err and out_valid together");

  // R5: an unflagged accepted entry keeps its base timestamp.
  a_r5_plain_passthrough : assert property (@(posedge clk) disable iff (rst)
    (in_valid && !inj_entry && bucket_addr <= ADDR_W'(LAST_BUCKET)) |=>
      (adj_ts == $past(base_ts)))
    else $error("unflagged entry timestamp altered");

  // R9: an idle cycle leaves the results untouched.
  a_r9_idle_holds : assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !addr_err && $stable(adj_ts) && $stable(fine_code)))
    else $error("idle cycle changed the outputs");

endmodule

// File: tb/sim_bucket_delay_splitter.sv
module sim_bucket_delay_splitter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [9:0]  bucket_addr = '0;
  logic [31:0] base_ts = '0;
  logic        inj_entry = 1'b0;
  logic        out_valid;
  logic [31:0] adj_ts;
  logic [1:0]  fine_code;
  logic        addr_err;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2ns clk = ~clk;

  bucket_delay_splitter u0 (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .bucket_addr (bucket_addr),
    .base_ts     (base_ts),
    .inj_entry   (inj_entry),
    .out_valid   (out_valid),
    .adj_ts      (adj_ts),
    .fine_code   (fine_code),
    .addr_err    (addr_err)
  );

  typedef struct packed {
    logic [9:0]  addr;
    logic        inj;
    logic [31:0] base;
    logic [31:0] exp_ts;
    logic [1:0]  exp_fine;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{10'd132, 1'b1, 32'd1000,        32'd1033,        2'd0}, // R3 R4
    '{10'd133, 1'b1, 32'd1000,        32'd1033,        2'd1}, // R3 R4
    '{10'd134, 1'b1, 32'd1000,        32'd1033,        2'd2}, // R3 R4
    '{10'd135, 1'b1, 32'd1000,        32'd1033,        2'd3}, // R3 R4
    '{10'd0,   1'b1, 32'd500,         32'd500,         2'd0}, // R8
    '{10'd827, 1'b1, 32'd0,           32'd206,         2'd3}, // R8
    '{10'd827, 1'b0, 32'd777,         32'd777,         2'd3}, // R5
    '{10'd5,   1'b0, 32'd12345,       32'd12345,       2'd1}, // R5
    '{10'd400, 1'b1, 32'hFFFF_FF00,   32'hFFFF_FF64,   2'd0}, // R3 near top
    '{10'd826, 1'b1, 32'hFFFF_FF31,   32'hFFFF_FFFF,   2'd2}, // R7 exact max
    '{10'd827, 1'b1, 32'hFFFF_FFF0,   32'hFFFF_FFFF,   2'd3}  // R7 saturate
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Present one entry for one cycle, then sample after the capturing edge.
  task automatic apply(input logic [9:0] a, input logic inj, input logic [31:0] b);
    @(negedge clk);
    in_valid    = 1'b1;
    bucket_addr = a;
    inj_entry   = inj;
    base_ts     = b;
    @(negedge clk);
    in_valid    = 1'b0;
  endtask

  initial begin
    #400us;
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 out_valid", 32'(out_valid), 32'd0);
    chk("R1 addr_err",  32'(addr_err),  32'd0);
    chk("R1 adj_ts",    adj_ts,         32'd0);
    chk("R1 fine_code", 32'(fine_code), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 out_valid after release", 32'(out_valid), 32'd0);
    chk("R1 adj_ts after release",    adj_ts,         32'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].addr, VECS[i].inj, VECS[i].base);
      chk("R2 out_valid",  32'(out_valid), 32'd1);
      chk("R6 no addr_err", 32'(addr_err), 32'd0);
      chk(VECS[i].inj ? "R3 adj_ts" : "R5 adj_ts", adj_ts, VECS[i].exp_ts);
      chk("R4 fine_code",  32'(fine_code), 32'(VECS[i].exp_fine));
    end

    // R9: idle cycle holds the last result
    @(negedge clk);
    chk("R9 out_valid idle", 32'(out_valid), 32'd0);
    chk("R9 addr_err idle",  32'(addr_err),  32'd0);
    chk("R9 adj_ts held",    adj_ts,         32'hFFFF_FFFF);
    chk("R9 fine held",      32'(fine_code), 32'd3);

    // Known result, then refused addresses 828 and 1023
    apply(10'd133, 1'b1, 32'd50);
    chk("R2 out_valid", 32'(out_valid), 32'd1);
    chk("R3 adj_ts",    adj_ts,         32'd83);
    apply(10'd828, 1'b1, 32'd9999);
    chk("R6 addr_err 828",  32'(addr_err),  32'd1);
    chk("R6 out_valid low", 32'(out_valid), 32'd0);
    chk("R6 adj_ts held",   adj_ts,         32'd83);
    chk("R6 fine held",     32'(fine_code), 32'd1);
    apply(10'd1023, 1'b0, 32'd7);
    chk("R6 addr_err 1023", 32'(addr_err),  32'd1);
    chk("R6 adj_ts held",   adj_ts,         32'd83);
    chk("R6 fine held",     32'(fine_code), 32'd1);
    @(negedge clk);
    chk("R9 addr_err cleared", 32'(addr_err), 32'd0);

    // R2: back-to-back strobes give back-to-back results
    @(negedge clk);
    in_valid = 1'b1; bucket_addr = 10'd8; inj_entry = 1'b1; base_ts = 32'd10;
    @(negedge clk);
    chk("R2 first of pair", adj_ts, 32'd12);
    bucket_addr = 10'd11; base_ts = 32'd20;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 second valid", 32'(out_valid), 32'd1);
    chk("R3 second adj",   adj_ts,         32'd22);
    chk("R4 second fine",  32'(fine_code), 32'd3);
    @(negedge clk);
    chk("R2 single pulse", 32'(out_valid), 32'd0);

    // R1: reset clears the results again
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 adj_ts cleared", adj_ts,         32'd0);
    chk("R1 fine cleared",   32'(fine_code), 32'd0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule